// File: doc/BRIEF.md
# Conflict-Driven Two-Way Instruction Cache

This block sits beside a three-stage fetch pipeline. Its only job is to hide the one-cycle penalty that arises when the program-memory bus must carry a data access in the same cycle as an instruction fetch. On such a cycle the pipeline presents the address of the instruction being fetched, which is two ahead of the instruction doing the data access. The cache answers in that same cycle: a hit returns the stored instruction, so the fetch completes alongside the data access; a miss raises a stall, and the core fetches the instruction from memory in the following cycle.

The instruction returned from memory in that following cycle is offered on the fill port. If the cache was enabled and not frozen when the miss occurred, the instruction is written into a two-way set-associative array, so that the next conflict at that address costs nothing. Each set has one replacement bit naming the entry that was not loaded most recently. A freeze control keeps the contents fixed while still serving hits. A disable control turns every lookup into a miss. An invalidate-all input clears the whole array.

Top module: `conflict_icache`

## Requirements
- R1: The array has 16 sets of two entries. Address bits 3..0 select the set and address bits 23..4 form the stored tag. A lookup hits only when an entry in the selected set is valid and its tag equals the lookup tag; an address differing only in tag bits misses.
- R2: While `lookup_valid` is low, `hit` and `stall` are both low, whatever the address and the array contents.
- R3: A hitting lookup drives `hit` high, `stall` low, and `instr_out` equal to the stored instruction, all in the lookup cycle itself.
- R4: A missing lookup drives `stall` high and `hit` low in the lookup cycle. This is exactly one stall cycle per miss, with the memory fetch in the next cycle. `instr_out` is zero whenever `hit` is low.
- R5: After a miss taken while enabled and not frozen, a `fill_valid` pulse in the very next cycle stores `fill_instr` under the missed address. If `fill_valid` is low in that cycle, nothing is stored.
- R6: A fill of a new address writes the entry named by the set's replacement bit (0 selects entry 0, 1 selects entry 1) and then points the bit at the other entry. A hit leaves the bit unchanged. So the third distinct address filled into a set evicts the first, even if the first has hit since.
- R7: While `cache_freeze` is high, misses store nothing and the replacement bits do not move, but lookups still hit on existing entries.
- R8: While `cache_enable` is low, every lookup misses and stalls and no fill takes place. Existing entries are kept and hit again once the cache is re-enabled.
- R9: Reset, or `invalidate_all` high at a clock edge, clears every valid bit and every replacement bit. A fill pending in that cycle is dropped.
- R10: A fill whose address is already present in its set (a repeated miss raised during the fill cycle) overwrites that entry in place and leaves the replacement bit unchanged, so later lookups return the newer instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_enable | input | 1 | High: lookups may hit and misses may fill |
| cache_freeze | input | 1 | High: contents and replacement bits held; hits still served |
| invalidate_all | input | 1 | Synchronous clear of all valid and replacement bits |
| lookup_valid | input | 1 | Program-memory bus carries a data access this cycle |
| lookup_addr | input | 24 | Address of the instruction being fetched in this cycle |
| fill_valid | input | 1 | Instruction from memory is present on `fill_instr` |
| fill_instr | input | 48 | Instruction fetched in the cycle after a miss |
| hit | output | 1 | Lookup served from the cache this cycle |
| stall | output | 1 | Lookup missed; core stalls one cycle |
| instr_out | output | 48 | Cached instruction on a hit, zero otherwise |

## Verification
The bench builds the block with its default widths: a 24-bit address, a 48-bit instruction and four index bits. At that size, every one of the 16 sets can be filled in both entries, probed and forced through an eviction in a single short run. Tags and instruction words are computed from the set number, so every expected hit, miss and returned word follows from arithmetic rather than from a stored model. The small set count also allows an invalidate sweep over all sets, and leaves room for the freeze, disable and repeated-miss orderings in dedicated sets.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the conflict-driven instruction cache.
// Assumes a fixed associativity of two; the way index is one bit wide.
package icache_pkg;
    localparam int NUM_WAYS = 2;
    localparam int WAY_W    = 1;
    typedef logic [WAY_W-1:0] way_idx_t;
endpackage

// File: rtl/icache_match.sv
`timescale 1ns/1ps
// Tag comparator for one set: compares the probe tag against every way.
// Assumes at most one way matches in normal use; if several do, the
// lowest-numbered way is reported.
module icache_match
    import icache_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [NUM_WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]               probe_tag,
    output logic                           any_hit,
    output way_idx_t                       hit_idx
);
    logic [NUM_WAYS-1:0] hit_vec;

    // One comparator per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
    end

    // Reduce the per-way results to a flag and a priority-encoded index.
    always_comb begin
        any_hit = |hit_vec;
        hit_idx = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_idx = way_idx_t'(w);
        end
    end
endmodule

// File: rtl/icache_store.sv
`timescale 1ns/1ps
// Tag and instruction storage, one write port and two read ports.
// The lookup port reads tags and instructions; the check port reads
// tags only, for the fill path. The data is not reset: validity
// lives in icache_state.
module icache_store
    import icache_pkg::*;
#(
    parameter int SET_W   = 4,
    parameter int TAG_W   = 20,
    parameter int INSTR_W = 48
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic [SET_W-1:0]                 wr_set,
    input  way_idx_t                         wr_way,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic [INSTR_W-1:0]               wr_instr,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [NUM_WAYS-1:0][INSTR_W-1:0] rd_instr,
    input  logic [SET_W-1:0]                 chk_set,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]   chk_tag
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0]   tag_mem   [SETS][NUM_WAYS];
    logic [INSTR_W-1:0] instr_mem [SETS][NUM_WAYS];

    // Write the selected entry when a fill is committed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set][wr_way]   <= wr_tag;
            instr_mem[wr_set][wr_way] <= wr_instr;
        end
    end

    // Asynchronous reads, one per way for each port.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign rd_tag[w]   = tag_mem[rd_set][w];
        assign rd_instr[w] = instr_mem[rd_set][w];
        assign chk_tag[w]  = tag_mem[chk_set][w];
    end
endmodule

// File: rtl/icache_state.sv
`timescale 1ns/1ps
// Valid bits per entry and one replacement bit per set. The replacement
// bit names the entry not loaded most recently. Assumes two ways, so
// "the other way" is the bit inverse of the way just loaded.
module icache_state
    import icache_pkg::*;
#(
    parameter int SET_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_all,
    input  logic                upd_en,
    input  logic [SET_W-1:0]    upd_set,
    input  way_idx_t            upd_way,
    input  logic                upd_flip,
    input  logic [SET_W-1:0]    rd_set,
    output logic [NUM_WAYS-1:0] rd_valid,
    input  logic [SET_W-1:0]    chk_set,
    output logic [NUM_WAYS-1:0] chk_valid,
    output logic                chk_lru
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0][NUM_WAYS-1:0] valid_q;
    logic [SETS-1:0]               lru_q;

    // Clear on reset or invalidate; otherwise mark a filled entry valid
    // and, for a new address, point the set at the other entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            valid_q <= '0;
            lru_q   <= '0;
        end else if (upd_en) begin
            valid_q[upd_set][upd_way] <= 1'b1;
            if (upd_flip) lru_q[upd_set] <= ~upd_way;
        end
    end

    // Combinational views for the lookup and fill paths.
    always_comb begin
        rd_valid  = valid_q[rd_set];
        chk_valid = valid_q[chk_set];
        chk_lru   = lru_q[chk_set];
    end
endmodule

// File: rtl/conflict_icache.sv
`timescale 1ns/1ps
// Conflict-driven two-way instruction cache. A lookup is presented only
// in cycles where the program-memory bus also carries a data access.
// The hit or stall answer is combinational in that cycle. A miss taken
// while enabled and not frozen arms a one-deep fill slot. The slot is
// consumed by fill_valid in the next cycle and dropped otherwise.
// Assumes the fetch unit supplies the fetched instruction exactly one
// cycle after the miss.
module conflict_icache
    import icache_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int INSTR_W = 48,
    parameter int SET_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_enable,
    input  logic               cache_freeze,
    input  logic               invalidate_all,
    input  logic               lookup_valid,
    input  logic [ADDR_W-1:0]  lookup_addr,
    input  logic               fill_valid,
    input  logic [INSTR_W-1:0] fill_instr,
    output logic               hit,
    output logic               stall,
    output logic [INSTR_W-1:0] instr_out
);
    localparam int TAG_W = ADDR_W - SET_W;

    logic [SET_W-1:0]                 look_set;
    logic [TAG_W-1:0]                 look_tag;
    logic [NUM_WAYS-1:0][TAG_W-1:0]   look_way_tag;
    logic [NUM_WAYS-1:0][INSTR_W-1:0] look_way_instr;
    logic [NUM_WAYS-1:0]              look_way_valid;
    logic                             look_match;
    way_idx_t                         look_idx;

    logic                             pend_q;
    logic [ADDR_W-1:0]                pend_addr_q;
    logic [SET_W-1:0]                 pend_set;
    logic [TAG_W-1:0]                 pend_tag;
    logic [NUM_WAYS-1:0][TAG_W-1:0]   chk_way_tag;
    logic [NUM_WAYS-1:0]              chk_way_valid;
    logic                             chk_lru;
    logic                             dup_match;
    way_idx_t                         dup_idx;

    logic                             arm_fill;
    logic                             fill_go;
    way_idx_t                         fill_way;

    // Split the lookup and pending addresses into index and tag.
    assign look_set = lookup_addr[SET_W-1:0];
    assign look_tag = lookup_addr[ADDR_W-1:SET_W];
    assign pend_set = pend_addr_q[SET_W-1:0];
    assign pend_tag = pend_addr_q[ADDR_W-1:SET_W];

    icache_store #(
        .SET_W   (SET_W),
        .TAG_W   (TAG_W),
        .INSTR_W (INSTR_W)
    ) u_store (
        .clk      (clk),
        .wr_en    (fill_go),
        .wr_set   (pend_set),
        .wr_way   (fill_way),
        .wr_tag   (pend_tag),
        .wr_instr (fill_instr),
        .rd_set   (look_set),
        .rd_tag   (look_way_tag),
        .rd_instr (look_way_instr),
        .chk_set  (pend_set),
        .chk_tag  (chk_way_tag)
    );

    icache_state #(
        .SET_W (SET_W)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (invalidate_all),
        .upd_en    (fill_go),
        .upd_set   (pend_set),
        .upd_way   (fill_way),
        .upd_flip  (!dup_match),
        .rd_set    (look_set),
        .rd_valid  (look_way_valid),
        .chk_set   (pend_set),
        .chk_valid (chk_way_valid),
        .chk_lru   (chk_lru)
    );

    icache_match #(
        .TAG_W (TAG_W)
    ) u_look_match (
        .way_tag   (look_way_tag),
        .way_valid (look_way_valid),
        .probe_tag (look_tag),
        .any_hit   (look_match),
        .hit_idx   (look_idx)
    );

    icache_match #(
        .TAG_W (TAG_W)
    ) u_dup_match (
        .way_tag   (chk_way_tag),
        .way_valid (chk_way_valid),
        .probe_tag (pend_tag),
        .any_hit   (dup_match),
        .hit_idx   (dup_idx)
    );

    // Answer the lookup in the same cycle: hit, or stall for one cycle.
    always_comb begin
        hit       = lookup_valid && cache_enable && look_match;
        stall     = lookup_valid && !hit;
        instr_out = hit ? look_way_instr[look_idx] : '0;
    end

    // Decide whether a miss may be captured and where the fill lands.
    always_comb begin
        arm_fill = lookup_valid && !hit && cache_enable && !cache_freeze
                   && !invalidate_all;
        fill_go  = pend_q && fill_valid && !invalidate_all;
        fill_way = dup_match ? dup_idx : way_idx_t'(chk_lru);
    end

    // Hold the missed address for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            pend_q <= arm_fill;
            if (arm_fill) pend_addr_q <= lookup_addr;
        end
    end
endmodule

// File: rtl/icache_checker.sv
`timescale 1ns/1ps
// Port-level properties of conflict_icache, attached through bind.
// Assumes the synchronous active-low reset is applied at start-up.
module icache_checker #(
    parameter int ADDR_W  = 24,
    parameter int INSTR_W = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cache_enable,
    input logic               cache_freeze,
    input logic               invalidate_all,
    input logic               lookup_valid,
    input logic [ADDR_W-1:0]  lookup_addr,
    input logic               fill_valid,
    input logic [INSTR_W-1:0] fill_instr,
    input logic               hit,
    input logic               stall,
    input logic [INSTR_W-1:0] instr_out
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |-> (!hit && !stall));

    p_hit_xor_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |-> (hit != stall));

    p_zero_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (instr_out == '0));

    p_disabled_misses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && !cache_enable) |-> stall);

    p_invalidate_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate_all |=> !hit);

    // R5: miss, fill in the next cycle, then the same address hits.
    p_fill_then_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) &&
         $past(lookup_valid, 2) && $past(stall, 2) &&
         $past(cache_enable, 2) && !$past(cache_freeze, 2) &&
         !$past(invalidate_all, 2) &&
         $past(fill_valid) && !$past(invalidate_all) &&
         lookup_valid && cache_enable &&
         lookup_addr == $past(lookup_addr, 2))
        |-> (hit && instr_out == $past(fill_instr)));
endmodule

bind conflict_icache icache_checker #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
) u_icache_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cache_enable   (cache_enable),
    .cache_freeze   (cache_freeze),
    .invalidate_all (invalidate_all),
    .lookup_valid   (lookup_valid),
    .lookup_addr    (lookup_addr),
    .fill_valid     (fill_valid),
    .fill_instr     (fill_instr),
    .hit            (hit),
    .stall          (stall),
    .instr_out      (instr_out)
);

// File: tb/test_conflict_icache.sv
`timescale 1ns/1ps
module test_conflict_icache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cache_enable;
    logic        cache_freeze;
    logic        invalidate_all;
    logic        lookup_valid;
    logic [23:0] lookup_addr;
    logic        fill_valid;
    logic [47:0] fill_instr;
    logic        hit;
    logic        stall;
    logic [47:0] instr_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    conflict_icache i_conflict_icache (
        .clk            (clk),
        .rst_n          (rst_n),
        .cache_enable   (cache_enable),
        .cache_freeze   (cache_freeze),
        .invalidate_all (invalidate_all),
        .lookup_valid   (lookup_valid),
        .lookup_addr    (lookup_addr),
        .fill_valid     (fill_valid),
        .fill_instr     (fill_instr),
        .hit            (hit),
        .stall          (stall),
        .instr_out      (instr_out)
    );

    function automatic logic [23:0] mk_addr(input int tag, input int set);
        return {20'(tag), 4'(set)};
    endfunction

    function automatic logic [47:0] mk_instr(input logic [23:0] a);
        return {a ^ 24'hC31E77, ~a};
    endfunction

    task automatic check(input bit ok, input string rid, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rid, what, act, exp);
        end
    endtask

    // Present one lookup, sample mid-cycle, compare hit/stall/instr.
    task automatic probe_i(input logic [23:0] a, input bit exp_hit,
                           input logic [47:0] exp_instr, input string rid);
        logic [47:0] want;
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_addr  = a;
        fill_valid   = 1'b0;
        #1;
        want = exp_hit ? exp_instr : 48'h0;
        check(hit == exp_hit && stall == !exp_hit && instr_out == want,
              rid, "hit,stall,instr",
              {14'h0, hit, stall, instr_out}, {14'h0, exp_hit, !exp_hit, want});
    endtask

    task automatic probe(input logic [23:0] a, input bit exp_hit, input string rid);
        probe_i(a, exp_hit, mk_instr(a), rid);
    endtask

    // Miss on an address, then return its instruction in the next cycle.
    task automatic miss_fill(input logic [23:0] a, input string rid);
        probe(a, 1'b0, rid);
        @(negedge clk);
        lookup_valid = 1'b0;
        fill_valid   = 1'b1;
        fill_instr   = mk_instr(a);
        @(negedge clk);
        fill_valid   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cache_enable = 1'b1; cache_freeze = 1'b0;
        invalidate_all = 1'b0; lookup_valid = 1'b0; lookup_addr = '0;
        fill_valid = 1'b0; fill_instr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!hit && !stall && instr_out == 0, "R9", "reset outputs",
              {14'h0, hit, stall, instr_out}, 64'h0);

        // R1/R4: empty array misses everywhere.
        for (int s = 0; s < 16; s++) probe(mk_addr(s + 1, s), 1'b0, "R4");

        // R1/R3/R5: fill both entries of every set, then probe both.
        for (int s = 0; s < 16; s++) begin
            miss_fill(mk_addr(s + 1, s), "R5");
            miss_fill(mk_addr(s + 'h100, s), "R5");
        end
        for (int s = 0; s < 16; s++) begin
            probe(mk_addr(s + 1, s), 1'b1, "R3");
            probe(mk_addr(s + 'h100, s), 1'b1, "R3");
            probe(mk_addr(s + 'h300, s), 1'b0, "R1");
        end

        // R2: idle bus with a resident address produces neither output.
        @(negedge clk);
        lookup_valid = 1'b0;
        lookup_addr  = mk_addr(4, 3);
        #1;
        check(!hit && !stall, "R2", "idle hit,stall", {62'h0, hit, stall}, 64'h0);

        // R6: hit first entry, fill a third address; first is evicted.
        for (int s = 0; s < 16; s++) begin
            probe(mk_addr(s + 1, s), 1'b1, "R6");
            miss_fill(mk_addr(s + 'h200, s), "R6");
            probe(mk_addr(s + 1, s), 1'b0, "R6");
            probe(mk_addr(s + 'h100, s), 1'b1, "R6");
            probe(mk_addr(s + 'h200, s), 1'b1, "R6");
        end

        // R5: a miss with no fill in the next cycle stores nothing.
        probe(mk_addr('h777, 6), 1'b0, "R5");
        @(negedge clk);
        lookup_valid = 1'b0;
        probe(mk_addr('h777, 6), 1'b0, "R5");

        // R7: frozen cache keeps serving hits and takes no fills.
        cache_freeze = 1'b1;
        miss_fill(mk_addr('h555, 5), "R7");
        probe(mk_addr('h555, 5), 1'b0, "R7");
        probe(mk_addr(5 + 'h100, 5), 1'b1, "R7");
        probe(mk_addr(5 + 'h200, 5), 1'b1, "R7");
        cache_freeze = 1'b0;
        // R7: replacement bit did not move: next new fill evicts 'h100.
        miss_fill(mk_addr('h556, 5), "R7");
        probe(mk_addr(5 + 'h100, 5), 1'b0, "R7");
        probe(mk_addr(5 + 'h200, 5), 1'b1, "R7");

        // R8: disabled cache misses, fills nothing, keeps its contents.
        cache_enable = 1'b0;
        probe(mk_addr(9 + 'h200, 9), 1'b0, "R8");
        miss_fill(mk_addr('h999, 9), "R8");
        cache_enable = 1'b1;
        probe(mk_addr(9 + 'h200, 9), 1'b1, "R8");
        probe(mk_addr(9 + 'h100, 9), 1'b1, "R8");
        probe(mk_addr('h999, 9), 1'b0, "R8");

        // R9: invalidate during a pending fill; everything misses after.
        probe(mk_addr('h444, 4), 1'b0, "R9");
        @(negedge clk);
        lookup_valid   = 1'b0;
        fill_valid     = 1'b1;
        fill_instr     = mk_instr(mk_addr('h444, 4));
        invalidate_all = 1'b1;
        @(negedge clk);
        fill_valid     = 1'b0;
        invalidate_all = 1'b0;
        for (int s = 0; s < 16; s++) begin
            probe(mk_addr(s + 'h200, s), 1'b0, "R9");
            probe(mk_addr(s + 'h100, s), 1'b0, "R9");
        end
        probe(mk_addr('h444, 4), 1'b0, "R9");

        // R10: repeated miss during the fill cycle overwrites in place.
        probe(mk_addr('h0A7, 7), 1'b0, "R10");
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_addr  = mk_addr('h0A7, 7);
        fill_valid   = 1'b1;
        fill_instr   = 48'h1111_2222_3333;
        #1;
        check(stall && !hit, "R10", "second miss", {62'h0, hit, stall}, 64'h1);
        @(negedge clk);
        lookup_valid = 1'b0;
        fill_valid   = 1'b1;
        fill_instr   = 48'h4444_5555_6666;
        @(negedge clk);
        fill_valid   = 1'b0;
        probe_i(mk_addr('h0A7, 7), 1'b1, 48'h4444_5555_6666, "R10");
        miss_fill(mk_addr('h0B7, 7), "R10");
        probe_i(mk_addr('h0A7, 7), 1'b1, 48'h4444_5555_6666, "R10");
        probe(mk_addr('h0B7, 7), 1'b1, "R10");

        @(negedge clk);
        lookup_valid = 1'b0;
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule